// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers a set of event lines (overflow flags, lock indications, general-purpose input pins) into one sticky status register and folds them into a single interrupt pin. Each source line is individually chosen to latch either while it is high (level) or on its rising edge (edge). Each source also has an enable mask that decides whether a latched bit can drive the interrupt pin. All source lines are treated as inputs. They pass through a synchronizer before use, so they may be asynchronous to the block clock.

Software sees a small register port. A read of the status word returns the latched events and clears them at that same clock edge. A level source that is still high sets its bit again at once. An edge source stays clear until its line falls and rises again. A control field picks how the pin is driven: active-high, active-low, or an open-drain style in which the pin is pulled low while the interrupt is pending and released otherwise. The reset input is asynchronous and active-low, and it is expected to be deasserted synchronously to `clk`.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, every register reads 0: status, trigger select, mask and output mode. The pin outputs are `irq_o`=0 and `irq_oe_o`=1.
- R2: A source whose trigger-select bit (register address 1, bit i for source i) is 0 sets status bit i while its synchronized line is high. The status bit is first visible 3 clock edges after the line rises. The bit stays set for as long as the line stays high, even right after a clear-on-read.
- R3: A source whose trigger-select bit is 1 sets status bit i on a rising edge of its synchronized line, with the same 3-edge latency. After a clear, the bit does not set again while the line stays high.
- R4: A set status bit stays set after its source returns low, until the status register is read.
- R5: The status register is at address 0, with source i at bit i. A read strobe there returns the current status combinationally and clears all bits at that clock edge. An event that arrives at that same edge is kept.
- R6: Writes to the status register have no effect on status or on any other register.
- R7: The mask register is at address 2, with bit i enabling source i (1 = enabled). The interrupt is pending when any status bit is set together with its mask bit. The pin reflects this one clock edge after the status or mask changes. Masked bits still latch and read back.
- R8: The output mode is held in register address 3, bits [1:0]. 00 gives active-high (`irq_o`=pending, `irq_oe_o`=1). 01 gives active-low (`irq_o`=not pending, `irq_oe_o`=1). 1x gives open-drain style (`irq_o`=0, `irq_oe_o`=pending). A mode change reaches the pin one edge after the write.
- R9: The configuration registers read back what was written, with the bits above NUM_SRC (or above bit 1 for the mode) reading 0. Addresses 4 and above read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Event source lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears status when address is 0) |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational from address |
| irq_o | output | 1 | Interrupt pin level |
| irq_oe_o | output | 1 | Interrupt pin drive enable |

## Verification
The bench builds the block with four sources, an 8-bit data word, a 3-bit address and a two-stage synchronizer. With four sources, all 16 trigger-select settings can be crossed with all 16 source patterns. Each of these cases is walked through latch, clear-on-read, hold and release, and the exact cycle each status bit appears is checked. All 16 masks and all four output modes are swept against a known pending state. Separate cases cover an event landing on the clearing edge, writes to the read-only status word, and the unmapped addresses.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  typedef enum logic [1:0] {
    OUT_HIGH   = 2'b00,
    OUT_LOW    = 2'b01,
    OUT_OD     = 2'b10,
    OUT_OD_ALT = 2'b11
  } out_mode_e;

  localparam int unsigned ADDR_STATUS = 0;
  localparam int unsigned ADDR_TRIG   = 1;
  localparam int unsigned ADDR_MASK   = 2;
  localparam int unsigned ADDR_MODE   = 3;

endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] level_o,
  output logic [NUM_SRC-1:0] rise_o
);

  logic [NUM_SRC-1:0] lvl;
  logic [NUM_SRC-1:0] prev_q;

  generate
    if (STAGES == 0) begin : g_bypass
      assign lvl = src_i;
    end else begin : g_sync
      logic [NUM_SRC-1:0] chain_q [STAGES];
      logic [NUM_SRC-1:0] chain_d [STAGES];

      always_comb begin
        chain_d[0] = src_i;
        for (int k = 1; k < int'(STAGES); k++) begin
          chain_d[k] = chain_q[k-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < int'(STAGES); k++) begin
            chain_q[k] <= '0;
          end
        end else begin
          for (int k = 0; k < int'(STAGES); k++) begin
            chain_q[k] <= chain_d[k];
          end
        end
      end

      assign lvl = chain_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= lvl;
    end
  end

  assign level_o = lvl;
  assign rise_o  = lvl & ~prev_q;

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] level_i,
  input  logic [NUM_SRC-1:0] rise_i,
  input  logic [NUM_SRC-1:0] trig_sel_i,
  input  logic               clr_i,
  output logic [NUM_SRC-1:0] status_o
);

  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] status_d;
  logic [NUM_SRC-1:0] set_w;

  generate
    for (genvar i = 0; i < int'(NUM_SRC); i++) begin : g_bit
      // select the event that may latch this bit
      assign set_w[i] = trig_sel_i[i] ? rise_i[i] : level_i[i];

      // R4: a latched bit survives until a read clears it
      a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[i] && !clr_i) |=> status_q[i]);

      // R5: a read with no concurrent event leaves the bit clear
      a_r5_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !level_i[i] && !rise_i[i]) |=> !status_q[i]);

      // R2: a high level source keeps its bit set
      a_r2_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_sel_i[i] && level_i[i]) |=> status_q[i]);

      // R3: an edge source without a new rise cannot re-assert
      a_r3_edge_once: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel_i[i] && !rise_i[i] && !status_q[i]) |=> !status_q[i]);
    end
  endgenerate

  always_comb begin
    status_d = (clr_i ? '0 : status_q) | set_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else begin
      status_q <= status_d;
    end
  end

  assign status_o = status_q;

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  input  logic [NUM_SRC-1:0] status_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic [NUM_SRC-1:0] trig_sel_o,
  output logic [NUM_SRC-1:0] mask_o,
  output out_mode_e          mode_o,
  output logic               status_clr_o
);

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADDR_STATUS);
  localparam logic [ADDR_W-1:0] A_TRIG   = ADDR_W'(ADDR_TRIG);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(ADDR_MASK);
  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(ADDR_MODE);

  logic [NUM_SRC-1:0] trig_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [1:0]         mode_q;
  logic               trig_en;
  logic               mask_en;
  logic               mode_en;

  always_comb begin
    trig_en      = reg_wr_i && (reg_addr_i == A_TRIG);
    mask_en      = reg_wr_i && (reg_addr_i == A_MASK);
    mode_en      = reg_wr_i && (reg_addr_i == A_MODE);
    status_clr_o = reg_rd_i && (reg_addr_i == A_STATUS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      mask_q <= '0;
      mode_q <= 2'b00;
    end else begin
      if (trig_en) trig_q <= reg_wdata_i[NUM_SRC-1:0];
      if (mask_en) mask_q <= reg_wdata_i[NUM_SRC-1:0];
      if (mode_en) mode_q <= reg_wdata_i[1:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_STATUS: reg_rdata_o[NUM_SRC-1:0] = status_i;
      A_TRIG:   reg_rdata_o[NUM_SRC-1:0] = trig_q;
      A_MASK:   reg_rdata_o[NUM_SRC-1:0] = mask_q;
      A_MODE:   reg_rdata_o[1:0]         = mode_q;
      default:  reg_rdata_o              = '0;
    endcase
  end

  assign trig_sel_o = trig_q;
  assign mask_o     = mask_q;
  assign mode_o     = out_mode_e'(mode_q);

  // R6: a write aimed at the status word leaves configuration untouched
  a_r6_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == A_STATUS) |=>
      ($stable(trig_q) && $stable(mask_q) && $stable(mode_q)));

endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive
  import irq_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      act_i,
  input  out_mode_e mode_i,
  output logic      irq_o,
  output logic      irq_oe_o
);

  logic out_d;
  logic oe_d;
  logic out_q;
  logic oe_q;

  always_comb begin
    case (mode_i)
      OUT_HIGH: begin out_d = act_i;  oe_d = 1'b1;  end
      OUT_LOW:  begin out_d = !act_i; oe_d = 1'b1;  end
      default:  begin out_d = 1'b0;   oe_d = act_i; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      oe_q  <= 1'b1;
    end else begin
      out_q <= out_d;
      oe_q  <= oe_d;
    end
  end

  assign irq_o    = out_q;
  assign irq_oe_o = oe_q;

  // R8: push-pull modes always drive the pin
  a_r8_push_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == OUT_HIGH || mode_i == OUT_LOW) |=> irq_oe_o);

  // R8: open-drain style never drives a high level
  a_r8_od_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i[1] |=> !irq_o);

  // R7: in active-high mode the pin follows the pending state one edge later
  a_r7_pin_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == OUT_HIGH) |=> (irq_o == $past(act_i)));

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_o,
  output logic               irq_oe_o
);

  logic [NUM_SRC-1:0] level_w;
  logic [NUM_SRC-1:0] rise_w;
  logic [NUM_SRC-1:0] status_w;
  logic [NUM_SRC-1:0] trig_w;
  logic [NUM_SRC-1:0] mask_w;
  out_mode_e          mode_w;
  logic               clr_w;
  logic               pending_w;

  irq_src_sync #(
    .NUM_SRC (NUM_SRC),
    .STAGES  (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_i   (src_i),
    .level_o (level_w),
    .rise_o  (rise_w)
  );

  irq_status_bank #(
    .NUM_SRC (NUM_SRC)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .level_i    (level_w),
    .rise_i     (rise_w),
    .trig_sel_i (trig_w),
    .clr_i      (clr_w),
    .status_o   (status_w)
  );

  irq_cfg_regs #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_i     (reg_wr_i),
    .reg_rd_i     (reg_rd_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .status_i     (status_w),
    .reg_rdata_o  (reg_rdata_o),
    .trig_sel_o   (trig_w),
    .mask_o       (mask_w),
    .mode_o       (mode_w),
    .status_clr_o (clr_w)
  );

  assign pending_w = |(status_w & mask_w);

  irq_pin_drive u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_i    (pending_w),
    .mode_i   (mode_w),
    .irq_o    (irq_o),
    .irq_oe_o (irq_oe_o)
  );

endmodule

// File: tb/irq_status_ctrl_tb.sv
`timescale 1ns/1ps
module irq_status_ctrl_tb;

  localparam int NS = 4;
  localparam int DW = 8;
  localparam int AW = 3;

  logic          clk;
  logic          rst_n;
  logic [NS-1:0] src;
  logic          wr;
  logic          rd;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          irq;
  logic          irq_oe;

  int n_chk;
  int n_err;

  irq_status_ctrl #(
    .NUM_SRC     (NS),
    .DATA_W      (DW),
    .ADDR_W      (AW),
    .SYNC_STAGES (2)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src),
    .reg_wr_i    (wr),
    .reg_rd_i    (rd),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq),
    .irq_oe_o    (irq_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_write(input int a, input int d);
    wr = 1'b1; addr = AW'(a); wdata = DW'(d);
    tick(1);
    wr = 1'b0; addr = '0;
  endtask

  task automatic reg_read(input int a, output logic [DW-1:0] d);
    rd = 1'b1; addr = AW'(a);
    #1 d = rdata;
    tick(1);
    rd = 1'b0; addr = '0;
  endtask

  function automatic logic [1:0] pin_exp(input int mode, input logic act);
    if (mode == 0) return {act, 1'b1};
    if (mode == 1) return {!act, 1'b1};
    return {1'b0, act};
  endfunction

  task automatic peek_status(input string tag, input int exp);
    addr = '0;
    #1 chk(tag, 32'(rdata), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; src = '0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      addr = AW'(a);
      #1 chk("R1 reset register", 32'(rdata), 0);
    end
    chk("R1 reset pin", {irq, irq_oe}, 2'b01);

    // R2 R3 R4 R5 R7: sweep every trigger select against every pattern
    for (int t = 0; t < 16; t++) begin
      for (int p = 0; p < 16; p++) begin
        int m;
        int lv;
        m  = (t * 7 + p * 3) & 15;
        lv = p & ~t & 15;
        reg_write(1, t);
        reg_write(2, m);
        src = NS'(p);
        tick(2);
        peek_status("R2 latency before", 0);
        tick(1);
        peek_status("R2 R3 latch", p);
        tick(1);
        chk("R7 pin pending", {irq, irq_oe}, pin_exp(0, (p & m) != 0));
        reg_read(0, d);
        chk("R5 read value", 32'(d), 32'(p));
        peek_status("R2 R3 after clear", lv);
        tick(2);
        peek_status("R3 no re-assert", lv);
        src = '0;
        tick(3);
        reg_read(0, d);
        chk("R4 sticky after drop", 32'(d), 32'(lv));
        peek_status("R5 cleared", 0);
        tick(1);
        chk("R7 pin idle", {irq, irq_oe}, pin_exp(0, 1'b0));
      end
    end

    // R7: every mask against a full pending state
    reg_write(1, 0);
    src = 4'hF;
    tick(3);
    for (int m = 0; m < 16; m++) begin
      reg_write(2, m);
      tick(1);
      chk("R7 mask sweep", {irq, irq_oe}, pin_exp(0, m != 0));
      peek_status("R7 masked still latched", 15);
    end

    // R8: every output mode, pending and idle
    for (int md = 0; md < 4; md++) begin
      for (int k = 0; k < 2; k++) begin
        reg_write(2, (k == 1) ? 15 : 0);
        reg_write(3, md);
        tick(1);
        chk("R8 output mode", {irq, irq_oe}, pin_exp(md, k == 1));
      end
    end
    reg_write(3, 0);

    // R6: status writes ignored
    reg_write(1, 4'h6);
    reg_write(2, 4'h9);
    reg_write(0, 8'h00);
    peek_status("R6 write zero ignored", 15);
    src = '0;
    tick(3);
    reg_read(0, d);
    reg_write(0, 8'hFF);
    peek_status("R6 write ones ignored", 0);
    addr = 3'd1; #1 chk("R6 trig unchanged", 32'(rdata), 32'h6);
    addr = 3'd2; #1 chk("R6 mask unchanged", 32'(rdata), 32'h9);

    // R9: readback widths and unmapped addresses
    reg_write(1, 8'hA5);
    addr = 3'd1; #1 chk("R9 trig readback", 32'(rdata), 32'h5);
    reg_write(3, 8'hFE);
    addr = 3'd3; #1 chk("R9 mode readback", 32'(rdata), 32'h2);
    reg_write(5, 8'hFF);
    for (int a = 4; a < 8; a++) begin
      addr = AW'(a);
      #1 chk("R9 unmapped reads zero", 32'(rdata), 0);
    end
    reg_write(3, 0);

    // R5: event landing on the clearing edge is kept
    reg_write(1, 4'b0001);
    src = 4'b0010;
    tick(1);
    src = '0;
    tick(4);
    peek_status("R5 setup", 2);
    src = 4'b0001;
    tick(2);
    reg_read(0, d);
    chk("R5 race read", 32'(d), 2);
    peek_status("R5 race kept", 1);
    src = '0;
    tick(3);
    reg_read(0, d);
    peek_status("R5 race cleared", 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule